// File: doc/BRIEF.md
# Greedy Task-to-Resource Assigner

This block binds pending communication tasks to routing resources. Tasks are the rows of a cost matrix and resources are its columns; each entry is the number of bus lines a route would occupy. A host loads the matrix into an internal single-port RAM through a write port while the block is idle, sets the configured sentinel cost, and pulses start.

The block then walks the rows in index order. For each row it reads every column cost, keeps the cheapest column that no earlier row has claimed, and locks that column. A row whose best free cost is at or above the sentinel is left pending: its column is still locked, but its cost is not summed. When the pass ends the block reports the column chosen for each row, the total cost of the real assignments and the number of pending rows, and pulses done. Because each row claims greedily, the same matrix with its rows reordered can give a different total.

Top module: `greedy_assigner`

## Requirements
- R1: After reset busy_o, done_o, assign_o, total_o and pend_cnt_o are all zero.
- R2: Rows are handled in ascending index order, and each row takes the free column with the smallest cost. On equal cost the lowest column index wins. The column for row r is reported in assign_o[r*COL_W +: COL_W].
- R3: A column taken by any row is locked for every later row of the same pass, so no two rows report the same column.
- R4: A row whose chosen cost is greater than or equal to sentinel_i is pending. It still locks its column and is counted in pend_cnt_o.
- R5: total_o is the sum of the chosen costs that are below sentinel_i.
- R6: Each cost read takes an address cycle and a data cycle, so done_o rises exactly 2*N_ROWS*N_COLS cycles after the edge that accepts start_i, is high for one cycle, and busy_o is high from acceptance until done_o falls.
- R7: start_i and matrix writes presented while busy_o is high are ignored.
- R8: assign_o, total_o and pend_cnt_o hold their values from done until the next accepted start.
- R9: Reordering the rows of a matrix can change total_o and pend_cnt_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write one matrix entry (idle only) |
| wr_row_i | input | ROW_W | Row (task) index of the write |
| wr_col_i | input | COL_W | Column (resource) index of the write |
| wr_cost_i | input | COST_W | Cost written |
| sentinel_i | input | COST_W | Cost at or above which a row is pending; hold stable during a pass |
| start_i | input | 1 | Start a pass (accepted when idle) |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle end-of-pass pulse |
| assign_o | output | N_ROWS*COL_W | Chosen column per row |
| total_o | output | TOT_W | Sum of non-pending chosen costs |
| pend_cnt_o | output | CNT_W | Number of pending rows |

## Verification
A corrupted column lock shows up at done as two rows reporting one column or a row skipping a cheaper free column, so each pass is compared field by field against an independent greedy model on the first cycle done is visible. A wrong best-cost register or tie rule shows the same way on matrices built from equal costs and from a single column every row prefers. Sequencer faults appear as a done pulse at the wrong cycle count, a second done, or outputs that drift while idle, all checked within the pass that caused them.

// File: rtl/ga_pkg.sv
package ga_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_DONE
  } ga_state_e;
endpackage

// File: rtl/ga_cost_ram.sv
module ga_cost_ram #(
  parameter int DEPTH  = 24,
  parameter int WIDTH  = 4,
  parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_q       <= mem_q[addr_i];
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/ga_col_lock.sv
module ga_col_lock #(
  parameter int N_COLS = 6,
  parameter int COL_W  = (N_COLS > 1) ? $clog2(N_COLS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             set_i,
  input  logic [COL_W-1:0] idx_i,
  output logic [N_COLS-1:0] mask_o
);
  logic [N_COLS-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= '0;
    else if (clr_i) mask_q <= '0;
    else if (set_i) mask_q[idx_i] <= 1'b1;
  end

  assign mask_o = mask_q;

  // R3
  lock_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> !mask_q[idx_i]);
endmodule

// File: rtl/greedy_assigner.sv
module greedy_assigner #(
  parameter int N_ROWS = 4,
  parameter int N_COLS = 6,
  parameter int COST_W = 4,
  localparam int ROW_W  = (N_ROWS > 1) ? $clog2(N_ROWS) : 1,
  localparam int COL_W  = (N_COLS > 1) ? $clog2(N_COLS) : 1,
  localparam int CNT_W  = $clog2(N_ROWS + 1),
  localparam int TOT_W  = COST_W + $clog2(N_ROWS + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ROW_W-1:0]        wr_row_i,
  input  logic [COL_W-1:0]        wr_col_i,
  input  logic [COST_W-1:0]       wr_cost_i,
  input  logic [COST_W-1:0]       sentinel_i,
  input  logic                    start_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [N_ROWS*COL_W-1:0] assign_o,
  output logic [TOT_W-1:0]        total_o,
  output logic [CNT_W-1:0]        pend_cnt_o
);
  import ga_pkg::*;

  localparam int DEPTH  = N_ROWS * N_COLS;
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LAT    = 2 * DEPTH;
  localparam int LAT_W  = $clog2(LAT + 1) + 1;

  ga_state_e state_q, state_d;
  logic [ROW_W-1:0]        row_q;
  logic [COL_W-1:0]        col_q;
  logic [COL_W-1:0]        best_col_q;
  logic [COST_W-1:0]       best_cost_q;
  logic                    best_vld_q;
  logic [N_ROWS*COL_W-1:0] asg_q;
  logic [TOT_W-1:0]        total_q;
  logic [CNT_W-1:0]        pend_q;

  logic                    idle, accept, last_col, last_row, commit;
  logic                    wr_ok, ram_en, take;
  logic [ADDR_W-1:0]       ram_addr;
  logic [COST_W-1:0]       rd_cost;
  logic [N_COLS-1:0]       used;
  logic [COL_W-1:0]        nb_col;
  logic [COST_W-1:0]       nb_cost;

  assign idle     = (state_q == ST_IDLE);
  assign accept   = idle && start_i;
  assign last_col = (col_q == COL_W'(N_COLS - 1));
  assign last_row = (row_q == ROW_W'(N_ROWS - 1));
  assign commit   = (state_q == ST_DATA) && last_col;

  // host writes only land while idle and in range
  assign wr_ok    = idle && wr_en_i && (int'(wr_row_i) < N_ROWS) && (int'(wr_col_i) < N_COLS);
  assign ram_en   = wr_ok || (state_q == ST_ADDR);
  assign ram_addr = idle ? ADDR_W'(int'(wr_row_i) * N_COLS + int'(wr_col_i))
                         : ADDR_W'(int'(row_q) * N_COLS + int'(col_q));

  ga_cost_ram #(.DEPTH(DEPTH), .WIDTH(COST_W), .ADDR_W(ADDR_W)) i_ram (
    .clk_i   (clk_i),
    .en_i    (ram_en),
    .we_i    (idle),
    .addr_i  (ram_addr),
    .wdata_i (wr_cost_i),
    .rdata_o (rd_cost)
  );

  ga_col_lock #(.N_COLS(N_COLS), .COL_W(COL_W)) i_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .set_i  (commit),
    .idx_i  (nb_col),
    .mask_o (used)
  );

  // strict less-than keeps the lowest index on ties
  assign take    = !used[col_q] && (!best_vld_q || (rd_cost < best_cost_q));
  assign nb_col  = take ? col_q   : best_col_q;
  assign nb_cost = take ? rd_cost : best_cost_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: state_d = (last_col && last_row) ? ST_DONE : ST_ADDR;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      row_q       <= '0;
      col_q       <= '0;
      best_col_q  <= '0;
      best_cost_q <= '0;
      best_vld_q  <= 1'b0;
      asg_q       <= '0;
      total_q     <= '0;
      pend_q      <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        row_q      <= '0;
        col_q      <= '0;
        best_vld_q <= 1'b0;
        asg_q      <= '0;
        total_q    <= '0;
        pend_q     <= '0;
      end else if (state_q == ST_DATA) begin
        if (last_col) begin
          asg_q[int'(row_q)*COL_W +: COL_W] <= nb_col;
          if (nb_cost < sentinel_i) total_q <= total_q + TOT_W'(nb_cost);
          else                      pend_q  <= pend_q + CNT_W'(1);
          best_vld_q <= 1'b0;
          col_q      <= '0;
          if (!last_row) row_q <= row_q + ROW_W'(1);
        end else begin
          best_col_q  <= nb_col;
          best_cost_q <= nb_cost;
          best_vld_q  <= best_vld_q || take;
          col_q       <= col_q + COL_W'(1);
        end
      end
    end
  end

  assign busy_o     = !idle;
  assign done_o     = (state_q == ST_DONE);
  assign assign_o   = asg_q;
  assign total_o    = total_q;
  assign pend_cnt_o = pend_q;

  // pass-length counter for the latency check
  logic [LAT_W-1:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lat_q <= '0;
    else if (accept)  lat_q <= '0;
    else if (!idle)   lat_q <= lat_q + LAT_W'(1);
  end

  // R2
  pick_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> (best_vld_q || take));
  // R4
  pend_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pend_cnt_o) <= N_ROWS);
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  // R6
  done_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (int'(lat_q) == LAT));
  // R7
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(assign_o) && $stable(total_o) && $stable(pend_cnt_o)));
endmodule

// File: tb/test_greedy_assigner.sv
`timescale 1ns/1ps
module test_greedy_assigner;
  localparam int R     = 4;
  localparam int C     = 6;
  localparam int CW    = 4;
  localparam int ROW_W = 2;
  localparam int COL_W = 3;
  localparam int CNT_W = 3;
  localparam int TOT_W = 7;
  localparam int LAT   = 2 * R * C;

  typedef struct {
    logic [R*COL_W-1:0] asg;
    int                 tot;
    int                 pend;
    string              tag;
  } exp_t;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               wr_en_i = 1'b0;
  logic [ROW_W-1:0]   wr_row_i = '0;
  logic [COL_W-1:0]   wr_col_i = '0;
  logic [CW-1:0]      wr_cost_i = '0;
  logic [CW-1:0]      sentinel_i = CW'(7);
  logic               start_i = 1'b0;
  logic               busy_o, done_o;
  logic [R*COL_W-1:0] assign_o;
  logic [TOT_W-1:0]   total_o;
  logic [CNT_W-1:0]   pend_cnt_o;

  int   checks = 0;
  int   errors = 0;
  int   mat [R][C];
  exp_t sb_q [$];
  exp_t last_exp;
  bit   finished = 0;

  always #5 clk_i = ~clk_i;

  greedy_assigner #(.N_ROWS(R), .N_COLS(C), .COST_W(CW)) i_greedy_assigner (
    .clk_i, .rst_ni, .wr_en_i, .wr_row_i, .wr_col_i, .wr_cost_i,
    .sentinel_i, .start_i, .busy_o, .done_o, .assign_o, .total_o, .pend_cnt_o
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // reference greedy rule
  function automatic exp_t model(int s, string tag);
    exp_t e;
    bit used [C];
    e.asg = '0; e.tot = 0; e.pend = 0; e.tag = tag;
    for (int c = 0; c < C; c++) used[c] = 0;
    for (int r = 0; r < R; r++) begin
      int best = -1;
      int bc   = 0;
      for (int c = 0; c < C; c++)
        if (!used[c] && (best < 0 || mat[r][c] < bc)) begin best = c; bc = mat[r][c]; end
      used[best] = 1;
      e.asg[r*COL_W +: COL_W] = COL_W'(best);
      if (bc < s) e.tot += bc; else e.pend++;
    end
    return e;
  endfunction

  task automatic load_matrix();
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) begin
        @(negedge clk_i);
        wr_en_i = 1'b1; wr_row_i = ROW_W'(r); wr_col_i = COL_W'(c); wr_cost_i = CW'(mat[r][c]);
      end
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // driver: push expectation, start, time the pass
  task automatic run_pass(string tag, bit poke);
    exp_t e;
    int   cnt = 0;
    e = model(int'(sentinel_i), tag);
    sb_q.push_back(e);
    last_exp = e;
    @(negedge clk_i);
    start_i = 1'b1;
    do begin
      @(negedge clk_i);
      start_i = 1'b0;
      wr_en_i = 1'b0;
      cnt++;
      if (poke && cnt == 10) begin
        start_i = 1'b1;
        wr_en_i = 1'b1; wr_row_i = '0; wr_col_i = '0; wr_cost_i = '0;
      end
    end while (!done_o && cnt < 1000);
    check({"R6 latency ", tag}, cnt, LAT + 1);
    @(negedge clk_i);
    check({"R6 busy low after done ", tag}, int'(busy_o), 0);
    check({"R6 done one cycle ", tag}, int'(done_o), 0);
  endtask

  // monitor: compare each result as done appears
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 unexpected done act=1 exp=0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (assign_o !== e.asg) begin
          errors++;
          $display("FAIL %s assign act=%h exp=%h", e.tag, assign_o, e.asg);
        end
        check({e.tag, " total"}, int'(total_o), e.tot);
        check({e.tag, " pending"}, int'(pend_cnt_o), e.pend);
      end
    end
  end

  task automatic hold_check(string tag);
    repeat (10) @(negedge clk_i);
    checks++;
    if (assign_o !== last_exp.asg) begin
      errors++;
      $display("FAIL R8 %s assign act=%h exp=%h", tag, assign_o, last_exp.asg);
    end
    check({"R8 total ", tag}, int'(total_o), last_exp.tot);
    check({"R8 pending ", tag}, int'(pend_cnt_o), last_exp.pend);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    int tot_a, tot_b, pend_a, pend_b;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 busy", int'(busy_o), 0);
    check("R1 done", int'(done_o), 0);
    check("R1 assign", int'(assign_o), 0);
    check("R1 total", int'(total_o), 0);
    check("R1 pending", int'(pend_cnt_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 distinct costs
    for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) mat[r][c] = (r*5 + c*3 + 2) % 7;
    load_matrix();
    run_pass("R2 distinct", 0);
    hold_check("after distinct");

    // R2 ties pick lowest index
    for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) mat[r][c] = 3;
    load_matrix();
    run_pass("R2 ties", 0);

    // R3 every row prefers column 2
    for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) mat[r][c] = (c == 2) ? 1 : 5 + r;
    load_matrix();
    run_pass("R3 lock", 0);

    // R4 R5 one row has only sentinel costs
    for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) mat[r][c] = (r == 1) ? 7 : (r + c) % 6;
    load_matrix();
    run_pass("R4 R5 sentinel row", 0);

    // R4 lower sentinel turns costs above it into pending rows
    sentinel_i = CW'(3);
    run_pass("R4 R5 sentinel input", 0);
    sentinel_i = CW'(7);

    // R9 row order dependence
    for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) mat[r][c] = 7;
    mat[0][0] = 1; mat[0][1] = 2; mat[1][0] = 1;
    load_matrix();
    run_pass("R9 order A", 0);
    tot_a = int'(total_o); pend_a = int'(pend_cnt_o);
    mat[0][1] = 7; mat[1][1] = 2;
    load_matrix();
    run_pass("R9 order B", 0);
    tot_b = int'(total_o); pend_b = int'(pend_cnt_o);
    check("R9 totals differ", int'(tot_a != tot_b), 1);
    check("R9 pending differ", int'(pend_a != pend_b), 1);

    // R7 start and write while busy are ignored
    for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) mat[r][c] = (r*5 + c*3 + 2) % 7;
    mat[0][0] = 6;
    load_matrix();
    run_pass("R7 poke during pass", 1);
    repeat (LAT + 5) @(negedge clk_i);
    check("R7 no second pass", int'(busy_o), 0);
    run_pass("R7 rerun unchanged", 0);
    hold_check("after rerun");

    repeat (5) @(negedge clk_i);
    check("R7 scoreboard drained", sb_q.size(), 0);
    finish_run();
  end
endmodule